// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A memory-mapped watchdog that watches a free-running 64-bit system count against an absolute compare value and escalates in two equal stages. While running, the compare value is kept at "count at last re-arm plus the programmed period". When the count reaches the compare value without a re-arm, the first-stage alarm `ws0` rises and the compare value is moved one further period ahead. If that second period also runs out, the reset request `ws1` rises. The total time from the last re-arm to the reset request is therefore twice the programmed period.

Software sees two register windows on a simple single-cycle read/write bus, picked by `bus_win`. The control window holds a control/status word, the 32-bit period and the 64-bit compare value, split into two 32-bit halves. The refresh window holds a kick word: a write of any value to it re-arms the watchdog. A write to the control word also re-arms, and so does a write to the period while the watchdog runs. Both windows carry two read-only identification words. Remaining time is found by reading the compare value and subtracting the current count.

Two resets exist. `por_rst_n` clears everything. `sys_rst_n` is the reset that the watchdog's own request causes. It clears everything except the sticky reset-request status bit, so that software can tell after boot that the watchdog caused the reset.

The sequencing is one state machine with four states. ST_OFF is idle, with both alarms low. ST_WATCH is the first stage. ST_ALERT is the second stage, with `ws0` high. ST_FIRED has both `ws0` and `ws1` high. The transitions are these:
- ST_WATCH to ST_ALERT on expiry, which also reloads the compare value.
- ST_ALERT to ST_FIRED on expiry, which also sets the sticky status bit.
- Any state to ST_WATCH on a re-arm that leaves the watchdog enabled.
- Any state to ST_OFF on a re-arm that disables it, or while the enable bit is clear.

Top module: `twostage_wdog`

## Requirements
- R1: After power-on reset, `ws0` and `ws1` are low. The control word, the period and both compare halves read 0.
- R2: Control window encoding: `bus_win`=0. Control/status at byte address 0x000 has enable in bit 0, first-stage status in bit 1 and sticky reset-request status in bit 2. Writing the control word re-arms: enable takes write-data bit 0, and the compare value becomes count + period.
- R3: In the first stage, once the count is equal to or above the compare value, `ws0` and status bit 1 go high after the next clock edge. The compare value becomes the count at that edge + period.
- R4: In the second stage, once the count is equal to or above the compare value, `ws1` and status bit 2 go high after the next clock edge. `ws0` stays high, and `ws1` is never high without `ws0`.
- R5: Refresh window encoding: `bus_win`=1. A write of any data to byte address 0x000 clears `ws0`, `ws1` and status bits 1 and 2, and sets the compare value to count + period. In that window, address 0x000 reads 0.
- R6: The period lives at control address 0x008. A write to it while enabled re-arms with the new period, so compare = count + new period. While disabled, it only stores the period and leaves the compare value unchanged.
- R7: While enable is 0, neither stage advances and `ws0`/`ws1` stay low, whatever the count.
- R8: `sys_rst_n` clears enable, period, compare value and both alarms, but status bit 2 keeps its value. `por_rst_n` clears status bit 2.
- R9: In both windows, address 0xFCC reads parameter IDENT_WORD and 0xFD0 reads parameter PART_WORD. Writes to them are ignored.
- R10: Unmapped addresses read 0, and writes to them change nothing. This includes control address 0x00C and 0x018.
- R11: The compare value is readable and writable as a low half at control address 0x010 and a high half at 0x014. A direct write moves the expiry point without re-arming the watchdog.
- R12: If a re-arm and an expiry fall on the same clock edge, the re-arm wins: no stage advance, and compare = count + period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, keeps the sticky reset-request status |
| sys_cnt | input | 64 | Free-running system count |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = control window, 1 = refresh window |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| ws0 | output | 1 | First-stage alarm |
| ws1 | output | 1 | Second-stage reset request |

## Verification
The bench lands the count exactly one below and then exactly on the compare value. A design that compared with strict greater-than, or reloaded from a stale count, would fire a cycle late or leave a wrong compare value. It puts a kick and an expiry on the same edge, which catches a design that lets the stage advance win. It writes the period while disabled and while enabled, because a design that re-armed on every period write, or used the old period, would show the wrong compare value. Finally it applies the system reset after a fired reset request and expects status bit 2 to survive while the alarms drop, then clears it with power-on reset. A design that tied the sticky bit to the system reset would lose the cause of the reset.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;

    localparam int AW = 12;

    localparam logic [AW-1:0] A_CTRL  = 12'h000;
    localparam logic [AW-1:0] A_OFFS  = 12'h008;
    localparam logic [AW-1:0] A_CMPL  = 12'h010;
    localparam logic [AW-1:0] A_CMPH  = 12'h014;
    localparam logic [AW-1:0] A_KICK  = 12'h000;
    localparam logic [AW-1:0] A_IDENT = 12'hFCC;
    localparam logic [AW-1:0] A_PART  = 12'hFD0;

    localparam int B_EN  = 0;
    localparam int B_WS0 = 1;
    localparam int B_WS1 = 2;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WATCH,
        ST_ALERT,
        ST_FIRED
    } wd_state_e;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_OFFS,
        RS_CMPL,
        RS_CMPH,
        RS_IDENT,
        RS_PART
    } rd_sel_e;

    typedef struct packed {
        logic kick;
        logic ctrl;
        logic offs;
        logic cmpl;
        logic cmph;
    } wr_strobe_t;

endpackage

// File: rtl/wdog_bus_port.sv
module wdog_bus_port
    import twostage_wdog_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] IDENT_WORD = 32'h5744_0101,
    parameter logic [31:0] PART_WORD  = 32'h0000_2A17
) (
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic                  bus_win,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  en_q,
    input  logic                  ws0_sts,
    input  logic                  ws1_sts,
    input  logic [DATA_W-1:0]     offset_q,
    input  logic [2*DATA_W-1:0]   cmp_q,
    output wr_strobe_t            strb,
    output logic [DATA_W-1:0]     bus_rdata
);

    rd_sel_e sel;

    // address decode of both windows
    always_comb begin
        strb = '0;
        sel  = RS_NONE;
        if (bus_valid) begin
            if (!bus_win) begin
                case (bus_addr)
                    A_CTRL:  begin strb.ctrl = bus_write; sel = RS_CTRL; end
                    A_OFFS:  begin strb.offs = bus_write; sel = RS_OFFS; end
                    A_CMPL:  begin strb.cmpl = bus_write; sel = RS_CMPL; end
                    A_CMPH:  begin strb.cmph = bus_write; sel = RS_CMPH; end
                    A_IDENT: sel = RS_IDENT;
                    A_PART:  sel = RS_PART;
                    default: sel = RS_NONE;
                endcase
            end else begin
                case (bus_addr)
                    A_KICK:  strb.kick = bus_write;
                    A_IDENT: sel = RS_IDENT;
                    A_PART:  sel = RS_PART;
                    default: sel = RS_NONE;
                endcase
            end
            if (bus_write) begin
                sel = RS_NONE;
            end
        end
    end

    // read data mux
    always_comb begin
        bus_rdata = '0;
        case (sel)
            RS_CTRL: begin
                bus_rdata[B_EN]  = en_q;
                bus_rdata[B_WS0] = ws0_sts;
                bus_rdata[B_WS1] = ws1_sts;
            end
            RS_OFFS:  bus_rdata = offset_q;
            RS_CMPL:  bus_rdata = cmp_q[DATA_W-1:0];
            RS_CMPH:  bus_rdata = cmp_q[2*DATA_W-1:DATA_W];
            RS_IDENT: bus_rdata = IDENT_WORD[DATA_W-1:0];
            RS_PART:  bus_rdata = PART_WORD[DATA_W-1:0];
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import twostage_wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  wr_strobe_t            strb,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [2*DATA_W-1:0]   cnt,
    input  logic                  reload,
    output logic                  en_q,
    output logic                  en_d,
    output logic [DATA_W-1:0]     offset_q,
    output logic [2*DATA_W-1:0]   cmp_q,
    output logic                  rearm,
    output logic                  expire
);

    localparam int CW = 2 * DATA_W;

    logic [DATA_W-1:0] ofs_d;
    logic [CW-1:0]     cmp_d;
    logic [CW-1:0]     half_we;

    assign en_d   = strb.ctrl ? wdata[B_EN] : en_q;
    assign ofs_d  = strb.offs ? wdata : offset_q;
    assign rearm  = strb.kick | strb.ctrl | (strb.offs & en_q);
    assign expire = (cnt >= cmp_q);

    // per-half write enables for the direct compare access
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic hit;
        assign hit = (h == 0) ? strb.cmpl : strb.cmph;
        assign half_we[h*DATA_W +: DATA_W] = {DATA_W{hit}};
    end

    always_comb begin
        if (rearm) begin
            cmp_d = cnt + {{DATA_W{1'b0}}, ofs_d};
        end else if (reload) begin
            cmp_d = cnt + {{DATA_W{1'b0}}, offset_q};
        end else begin
            cmp_d = (cmp_q & ~half_we) | ({wdata, wdata} & half_we);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            offset_q <= '0;
            cmp_q    <= '0;
        end else begin
            en_q     <= en_d;
            offset_q <= ofs_d;
            cmp_q    <= cmp_d;
        end
    end

endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
    import twostage_wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic por_rst_n,
    input  logic en_q,
    input  logic en_d,
    input  logic rearm,
    input  logic expire,
    output logic reload,
    output logic ws0,
    output logic ws1,
    output logic ws1_sts
);

    wd_state_e state_q;
    wd_state_e state_d;
    logic      fire;

    always_comb begin
        state_d = state_q;
        if (rearm) begin
            state_d = en_d ? ST_WATCH : ST_OFF;
        end else if (!en_q) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_WATCH;
                ST_WATCH: if (expire) state_d = ST_ALERT;
                ST_ALERT: if (expire) state_d = ST_FIRED;
                ST_FIRED: state_d = ST_FIRED;
            endcase
        end
    end

    assign reload = !rearm && en_q && (state_q == ST_WATCH) && expire;
    assign fire   = !rearm && en_q && (state_q == ST_ALERT) && expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // sticky reset-request status survives the system reset
    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            ws1_sts <= 1'b0;
        end else if (rearm) begin
            ws1_sts <= 1'b0;
        end else if (fire) begin
            ws1_sts <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ws0 = 1'b0;
        ws1 = 1'b0;
        unique case (state_q)
            ST_OFF:   ;
            ST_WATCH: ;
            ST_ALERT: ws0 = 1'b1;
            ST_FIRED: begin ws0 = 1'b1; ws1 = 1'b1; end
        endcase
    end

endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import twostage_wdog_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] IDENT_WORD = 32'h5744_0101,
    parameter logic [31:0] PART_WORD  = 32'h0000_2A17
) (
    input  logic                  clk,
    input  logic                  por_rst_n,
    input  logic                  sys_rst_n,
    input  logic [2*DATA_W-1:0]   sys_cnt,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic                  bus_win,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  ws0,
    output logic                  ws1
);

    logic                rst_n;
    wr_strobe_t          strb;
    logic                en_q;
    logic                en_d;
    logic [DATA_W-1:0]   offset_q;
    logic [2*DATA_W-1:0] cmp_q;
    logic                rearm;
    logic                expire;
    logic                reload;
    logic                ws1_sts;

    assign rst_n = por_rst_n & sys_rst_n;

    wdog_bus_port #(
        .DATA_W     (DATA_W),
        .IDENT_WORD (IDENT_WORD),
        .PART_WORD  (PART_WORD)
    ) u_port (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_win   (bus_win),
        .bus_addr  (bus_addr),
        .en_q      (en_q),
        .ws0_sts   (ws0),
        .ws1_sts   (ws1_sts),
        .offset_q  (offset_q),
        .cmp_q     (cmp_q),
        .strb      (strb),
        .bus_rdata (bus_rdata)
    );

    wdog_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb     (strb),
        .wdata    (bus_wdata),
        .cnt      (sys_cnt),
        .reload   (reload),
        .en_q     (en_q),
        .en_d     (en_d),
        .offset_q (offset_q),
        .cmp_q    (cmp_q),
        .rearm    (rearm),
        .expire   (expire)
    );

    wdog_stage_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_rst_n (por_rst_n),
        .en_q      (en_q),
        .en_d      (en_d),
        .rearm     (rearm),
        .expire    (expire),
        .reload    (reload),
        .ws0       (ws0),
        .ws1       (ws1),
        .ws1_sts   (ws1_sts)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import twostage_wdog_pkg::*;
(
    input logic          clk,
    input logic          por_rst_n,
    input logic          sys_rst_n,
    input logic          bus_valid,
    input logic          bus_write,
    input logic          bus_win,
    input logic [AW-1:0] bus_addr,
    input logic          ws0,
    input logic          ws1,
    input logic          en_q,
    input logic          ws1_sts,
    input logic          rearm
);

    logic kick_wr;
    assign kick_wr = bus_valid && bus_write && bus_win && (bus_addr == A_KICK);

    // R4
    ws1_implies_ws0_chk: assert property (@(posedge clk) disable iff (!por_rst_n || !sys_rst_n)
        ws1 |-> ws0);

    // R4
    ws1_after_ws0_chk: assert property (@(posedge clk) disable iff (!por_rst_n || !sys_rst_n)
        $rose(ws1) |-> $past(ws0));

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!por_rst_n || !sys_rst_n)
        !en_q |-> (!ws0 && !ws1));

    // R3
    ws0_needs_en_chk: assert property (@(posedge clk) disable iff (!por_rst_n || !sys_rst_n)
        $rose(ws0) |-> $past(en_q));

    // R5
    kick_clears_chk: assert property (@(posedge clk) disable iff (!por_rst_n || !sys_rst_n)
        kick_wr |=> (!ws0 && !ws1 && !ws1_sts));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        $fell(ws1_sts) |-> $past(rearm));

endmodule

bind twostage_wdog wdog_chk u_chk (
    .clk       (clk),
    .por_rst_n (por_rst_n),
    .sys_rst_n (sys_rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_win   (bus_win),
    .bus_addr  (bus_addr),
    .ws0       (ws0),
    .ws1       (ws1),
    .en_q      (en_q),
    .ws1_sts   (ws1_sts),
    .rearm     (rearm)
);

// File: tb/twostage_wdog_tb_top.sv
`timescale 1ns/1ps
module twostage_wdog_tb_top;

    localparam logic [31:0] IDV = 32'h5744_0101;
    localparam logic [31:0] PNV = 32'h0000_2A17;

    logic        clk = 1'b0;
    logic        por_rst_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic [63:0] sys_cnt = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_win = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ws0;
    logic        ws1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    twostage_wdog #(.IDENT_WORD(IDV), .PART_WORD(PNV)) dut_i (
        .clk       (clk),
        .por_rst_n (por_rst_n),
        .sys_rst_n (sys_rst_n),
        .sys_cnt   (sys_cnt),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_win   (bus_win),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ws0       (ws0),
        .ws1       (ws1)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_win = win; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic win, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_win = win; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic step_cnt(input logic [63:0] v);
        @(negedge clk);
        sys_cnt = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 ws0", {63'd0, ws0}, 64'd0);
        chk("R1 ws1", {63'd0, ws1}, 64'd0);
        rd(1'b0, 12'h000, d); chk("R1 ctrl", {32'd0, d}, 64'd0);
        rd(1'b0, 12'h008, d); chk("R1 period", {32'd0, d}, 64'd0);
        rd(1'b0, 12'h010, d); chk("R1 cmp lo", {32'd0, d}, 64'd0);
        rd(1'b0, 12'h014, d); chk("R1 cmp hi", {32'd0, d}, 64'd0);
    endtask

    task automatic t_start();
        logic [31:0] d;
        sys_cnt = 64'd1000;
        wr(1'b0, 12'h008, 32'd100);
        rd(1'b0, 12'h010, d); chk("R6 disabled period write keeps cmp", {32'd0, d}, 64'd0);
        rd(1'b0, 12'h008, d); chk("R6 period stored", {32'd0, d}, 64'd100);
        wr(1'b0, 12'h000, 32'd1);
        rd(1'b0, 12'h010, d); chk("R2 cmp = cnt + period", {32'd0, d}, 64'd1100);
        rd(1'b0, 12'h000, d); chk("R2 enable bit", {32'd0, d}, 64'd1);
    endtask

    task automatic t_stages();
        logic [31:0] d;
        step_cnt(64'd1099); chk("R3 below cmp no ws0", {63'd0, ws0}, 64'd0);
        step_cnt(64'd1100); chk("R3 ws0 at cmp", {63'd0, ws0}, 64'd1);
        rd(1'b0, 12'h000, d); chk("R3 status", {32'd0, d}, 64'd3);
        rd(1'b0, 12'h010, d); chk("R3 cmp reload", {32'd0, d}, 64'd1200);
        step_cnt(64'd1199); chk("R4 below cmp no ws1", {63'd0, ws1}, 64'd0);
        step_cnt(64'd1200); chk("R4 ws1 at 2x period", {63'd0, ws1}, 64'd1);
        chk("R4 ws0 held", {63'd0, ws0}, 64'd1);
        rd(1'b0, 12'h000, d); chk("R4 status", {32'd0, d}, 64'd7);
    endtask

    task automatic t_refresh();
        logic [31:0] d;
        sys_cnt = 64'd1300;
        wr(1'b1, 12'h000, 32'hDEAD_BEEF);
        chk("R5 ws0 cleared", {63'd0, ws0}, 64'd0);
        chk("R5 ws1 cleared", {63'd0, ws1}, 64'd0);
        rd(1'b0, 12'h000, d); chk("R5 status", {32'd0, d}, 64'd1);
        rd(1'b0, 12'h010, d); chk("R5 cmp reload", {32'd0, d}, 64'd1400);
        rd(1'b1, 12'h000, d); chk("R5 kick reads 0", {32'd0, d}, 64'd0);
    endtask

    task automatic t_offset_live();
        logic [31:0] d;
        sys_cnt = 64'd1360;
        wr(1'b0, 12'h008, 32'd50);
        rd(1'b0, 12'h010, d); chk("R6 enabled period write re-arms", {32'd0, d}, 64'd1410);
    endtask

    task automatic t_cmp_direct();
        logic [31:0] d;
        wr(1'b0, 12'h010, 32'd1500);
        rd(1'b0, 12'h010, d); chk("R11 cmp lo write", {32'd0, d}, 64'd1500);
        step_cnt(64'd1410); chk("R11 old point no ws0", {63'd0, ws0}, 64'd0);
        step_cnt(64'd1500); chk("R11 new point ws0", {63'd0, ws0}, 64'd1);
        rd(1'b0, 12'h010, d); chk("R11 reload lo", {32'd0, d}, 64'd1550);
        wr(1'b0, 12'h014, 32'd1);
        rd(1'b0, 12'h014, d); chk("R11 cmp hi write", {32'd0, d}, 64'd1);
        chk("R11 hi write no re-arm", {63'd0, ws0}, 64'd1);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        sys_cnt = 64'd2000;
        wr(1'b1, 12'h000, 32'd0);
        rd(1'b0, 12'h014, d); chk("R5 cmp hi after kick", {32'd0, d}, 64'd0);
        @(negedge clk);
        sys_cnt = 64'd2050;
        bus_valid = 1'b1; bus_write = 1'b1; bus_win = 1'b1; bus_addr = 12'h000; bus_wdata = 32'd7;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        chk("R12 kick beats expiry ws0", {63'd0, ws0}, 64'd0);
        rd(1'b0, 12'h010, d); chk("R12 cmp", {32'd0, d}, 64'd2100);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        sys_cnt = 64'd2100;
        wr(1'b0, 12'h000, 32'd0);
        step_cnt(64'd5000);
        step_cnt(64'd9000);
        chk("R7 no ws0 when off", {63'd0, ws0}, 64'd0);
        chk("R7 no ws1 when off", {63'd0, ws1}, 64'd0);
        rd(1'b0, 12'h000, d); chk("R7 status", {32'd0, d}, 64'd0);
    endtask

    task automatic t_sysreset();
        logic [31:0] d;
        sys_cnt = 64'd3000;
        wr(1'b0, 12'h000, 32'd1);
        step_cnt(64'd3050);
        step_cnt(64'd3100);
        chk("R8 fired before reset", {63'd0, ws1}, 64'd1);
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
        chk("R8 ws1 low after sys reset", {63'd0, ws1}, 64'd0);
        chk("R8 ws0 low after sys reset", {63'd0, ws0}, 64'd0);
        rd(1'b0, 12'h000, d); chk("R8 sticky survives", {32'd0, d}, 64'd4);
        rd(1'b0, 12'h008, d); chk("R8 period cleared", {32'd0, d}, 64'd0);
        @(negedge clk); por_rst_n = 1'b0;
        @(negedge clk); por_rst_n = 1'b1;
        rd(1'b0, 12'h000, d); chk("R8 por clears sticky", {32'd0, d}, 64'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(1'b0, 12'h018, 32'hFFFF_FFFF);
        wr(1'b0, 12'h00C, 32'hFFFF_FFFF);
        rd(1'b0, 12'h000, d); chk("R10 ctrl unchanged", {32'd0, d}, 64'd0);
        rd(1'b0, 12'h008, d); chk("R10 period unchanged", {32'd0, d}, 64'd0);
        rd(1'b0, 12'h018, d); chk("R10 0x018 reads 0", {32'd0, d}, 64'd0);
        rd(1'b0, 12'h00C, d); chk("R10 0x00C reads 0", {32'd0, d}, 64'd0);
    endtask

    task automatic t_id();
        logic [31:0] d;
        wr(1'b0, 12'hFCC, 32'h0);
        rd(1'b0, 12'hFCC, d); chk("R9 ctrl ident", {32'd0, d}, {32'd0, IDV});
        rd(1'b0, 12'hFD0, d); chk("R9 ctrl part", {32'd0, d}, {32'd0, PNV});
        rd(1'b1, 12'hFCC, d); chk("R9 kick ident", {32'd0, d}, {32'd0, IDV});
        rd(1'b1, 12'hFD0, d); chk("R9 kick part", {32'd0, d}, {32'd0, PNV});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_stages();
        t_refresh();
        t_offset_live();
        t_cmp_direct();
        t_priority();
        t_disable();
        t_sysreset();
        t_unmapped();
        t_id();
        done = 1'b1;
        summary();
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

endmodule